// File: doc/BRIEF.md
# NAND Flash Device Responder

This block stands in for the device side of an 8-bit NAND flash so that a flash host controller can be exercised without an external memory model. It watches the host's latch and strobe pins (command latch, address latch, active-low write strobe, read strobe and chip select) and returns data on an 8-bit bus with an output enable. It also pulls an open-drain ready/busy line low while a modelled array access is in progress. Every pin is sampled on a system clock, and strobe edges are found by comparing each sample with the one before it. A host strobe must therefore stay at each level for at least two clock periods.

The block understands four things: an identification query, a page read built from a setup command, five address bytes and a confirm command, serial data-out with an auto-incrementing column, and a reset command. Page contents come from a fixed formula, so a bench can predict every byte without loading a memory. The data path is a set of pins run by strobes, not a stream, so there is no valid/ready handshake and no back-pressure: the host sets the pace with its strobes.

Top module: `nand_responder`

## Requirements
- R1: After reset, rdy_pull_low is 0 and dq_oe is 0. A read strobe given before any command drives nothing.
- R2: Command 0x90 followed by one address byte makes the next read strobes return 0xEC, then DEVICE_CODE (default 0xDA), then 0x00 for every further strobe.
- R3: Each falling read strobe with sel_n low drives one byte and moves the column on by one. A page byte equals (0x17 + 29*row + 7*column) mod 256.
- R4: Setup command 0x00, five address bytes and then confirm command 0x30 hold rdy_pull_low at 1 for exactly BUSY_CYCLES clock cycles. After that, reads start at the addressed column.
- R5: The first address byte gives the column and the third gives the row. The second, fourth and fifth bytes are discarded. Only the low log2(PAGE_BYTES) column bits and the low log2(PAGES) row bits are used, and the column wraps to 0 after the last byte of a page.
- R6: While sel_n is high, write and read strobes are ignored and dq_oe stays 0. Raising sel_n during busy does not shorten the busy time.
- R7: A confirm command 0x30 that does not follow the setup command and all five address bytes is ignored: rdy_pull_low stays 0 and reads drive nothing.
- R8: While busy, read strobes drive nothing, and every write except command 0xFF is ignored.
- R9: Command 0xFF returns the block to idle at any time. During busy it releases rdy_pull_low within two cycles, and later reads drive nothing until a new command arrives.
- R10: dq_oe is 1 only while the read strobe is low. It falls within two clock cycles after rd_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_latch | input | 1 | High marks the bus byte as a command |
| addr_latch | input | 1 | High marks the bus byte as an address byte |
| wr_n | input | 1 | Write strobe; the byte is taken on its rising edge |
| rd_n | input | 1 | Read strobe; a falling edge fetches the next byte |
| sel_n | input | 1 | Active-low device select |
| dq_in | input | 8 | Bus byte from the host |
| dq_out | output | 8 | Bus byte to the host |
| dq_oe | output | 1 | Bus drive enable (bus released when 0) |
| rdy_pull_low | output | 1 | 1 pulls the open-drain ready/busy line low |

## Verification
A mode register that has strayed shows up at the first read strobe after it: dq_oe either rises when it should not or stays low, about two cycles after rd_n falls. A column counter that steps wrongly gives a wrong byte on the very next strobe, and the formula lets the bench predict that byte exactly. A busy counter loaded with the wrong value shows only at the release of ready/busy, so the bench measures the length of every busy run cycle by cycle. It also flags busy at any moment the reference does not expect it.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ID_ADDR,
    M_ID_OUT,
    M_RD_ADDR,
    M_RD_CONF,
    M_RD_BUSY,
    M_RD_OUT
  } mode_e;

  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_SETUP = 8'h00;
  localparam logic [7:0] OP_READ_GO    = 8'h30;
  localparam logic [7:0] OP_RESET      = 8'hFF;

  localparam int ADDR_BYTES = 5;
  localparam int COL_BYTE   = 0;
  localparam int ROW_BYTE   = 2;

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       sel_n,
  input  logic [7:0] dq_in,
  output logic       s_cmd,
  output logic       s_addr,
  output logic       s_sel_n,
  output logic       s_rd_n,
  output logic [7:0] s_dq,
  output logic       wr_rise,
  output logic       rd_fall
);

  logic s_wr_n, p_wr_n, p_rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cmd   <= 1'b0;
      s_addr  <= 1'b0;
      s_sel_n <= 1'b1;
      s_wr_n  <= 1'b1;
      s_rd_n  <= 1'b1;
      p_wr_n  <= 1'b1;
      p_rd_n  <= 1'b1;
      s_dq    <= '0;
    end else begin
      s_cmd   <= cmd_latch;
      s_addr  <= addr_latch;
      s_sel_n <= sel_n;
      s_wr_n  <= wr_n;
      s_rd_n  <= rd_n;
      p_wr_n  <= s_wr_n;
      p_rd_n  <= s_rd_n;
      s_dq    <= dq_in;
    end
  end

  assign wr_rise = ~p_wr_n & s_wr_n;
  assign rd_fall = p_rd_n & ~s_rd_n;

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_resp_pkg::*;
#(
  parameter int BUSY_CYCLES = 20,
  parameter int COL_W       = 4,
  parameter int ROW_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rise,
  input  logic             s_cmd,
  input  logic             s_addr,
  input  logic             s_sel_n,
  input  logic [7:0]       s_dq,
  output mode_e            mode,
  output logic             busy,
  output logic             col_load,
  output logic             id_load,
  output logic [COL_W-1:0] col_start,
  output logic [ROW_W-1:0] row_sel
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [2:0] LAST_ADDR = 3'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       acnt;
  logic             wr_ok, abort;

  assign wr_ok = wr_rise & ~s_sel_n;
  assign abort = wr_ok & s_cmd & (s_dq == OP_RESET);
  assign busy  = (mode == M_RD_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      cnt       <= '0;
      acnt      <= '0;
      col_load  <= 1'b0;
      id_load   <= 1'b0;
      col_start <= '0;
      row_sel   <= '0;
    end else begin
      col_load <= 1'b0;
      id_load  <= 1'b0;
      if (mode == M_RD_BUSY) begin
        if (abort) begin
          mode <= M_IDLE;
        end else if (cnt == '0) begin
          mode     <= M_RD_OUT;
          col_load <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (wr_ok && s_cmd) begin
        case (s_dq)
          OP_READ_ID:    mode <= M_ID_ADDR;
          OP_READ_SETUP: begin
            mode <= M_RD_ADDR;
            acnt <= '0;
          end
          OP_READ_GO: begin
            if (mode == M_RD_CONF) begin
              mode <= M_RD_BUSY;
              cnt  <= CNT_LOAD;
            end
          end
          default:       mode <= M_IDLE;
        endcase
      end else if (wr_ok && s_addr) begin
        if (mode == M_ID_ADDR) begin
          mode    <= M_ID_OUT;
          id_load <= 1'b1;
        end else if (mode == M_RD_ADDR) begin
          if (acnt == 3'(COL_BYTE)) col_start <= s_dq[COL_W-1:0];
          if (acnt == 3'(ROW_BYTE)) row_sel   <= s_dq[ROW_W-1:0];
          acnt <= acnt + 3'd1;
          if (acnt == LAST_ADDR) mode <= M_RD_CONF;
        end
      end
    end
  end

  AST_BUSY_STARTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == CNT_LOAD)); // R4

  AST_CONFIRM_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode) == M_RD_CONF)); // R7

  AST_ADDR_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RD_ADDR) |-> (acnt < 3'(ADDR_BYTES))); // R5

  AST_RESET_FREES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy); // R9

endmodule

// File: rtl/nand_data_port.sv
module nand_data_port
  import nand_resp_pkg::*;
#(
  parameter int         COL_W       = 4,
  parameter int         ROW_W       = 2,
  parameter logic [7:0] MAKER_CODE  = 8'hEC,
  parameter logic [7:0] DEVICE_CODE = 8'hDA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fall,
  input  logic             s_rd_n,
  input  logic             s_sel_n,
  input  mode_e            mode,
  input  logic             col_load,
  input  logic             id_load,
  input  logic [COL_W-1:0] col_start,
  input  logic [ROW_W-1:0] row_sel,
  output logic [7:0]       dq_out,
  output logic             dq_oe
);

  logic [COL_W-1:0] col;
  logic [1:0]       id_idx;
  logic [7:0]       id_byte, page_byte;
  logic             busy, fetch_ok;

  assign busy     = (mode == M_RD_BUSY);
  assign fetch_ok = rd_fall & ~s_sel_n & ~busy;

  always_comb begin
    case (id_idx)
      2'd0:    id_byte = MAKER_CODE;
      2'd1:    id_byte = DEVICE_CODE;
      default: id_byte = 8'h00;
    endcase
  end

  assign page_byte = 8'h17 + 8'(row_sel) * 8'd29 + 8'(col) * 8'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col    <= '0;
      id_idx <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (col_load) col <= col_start;
      if (id_load) id_idx <= '0;
      if (fetch_ok && mode == M_ID_OUT) begin
        dq_out <= id_byte;
        dq_oe  <= 1'b1;
        if (id_idx != 2'd2) id_idx <= id_idx + 2'd1;
      end else if (fetch_ok && mode == M_RD_OUT) begin
        dq_out <= page_byte;
        dq_oe  <= 1'b1;
        if (!col_load) col <= col + 1'b1;
      end else if (s_rd_n || s_sel_n || busy) begin
        dq_oe <= 1'b0;
      end
    end
  end

  AST_COL_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ok && mode == M_RD_OUT && !col_load) |=> (col == $past(col) + 1'b1)); // R3

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    s_sel_n |=> !dq_oe); // R6

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dq_oe); // R8

  AST_RELEASE_ON_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    s_rd_n |=> !dq_oe); // R10

endmodule

// File: rtl/nand_responder.sv
module nand_responder
  import nand_resp_pkg::*;
#(
  parameter int         PAGES       = 4,
  parameter int         PAGE_BYTES  = 16,
  parameter int         BUSY_CYCLES = 20,
  parameter logic [7:0] MAKER_CODE  = 8'hEC,
  parameter logic [7:0] DEVICE_CODE = 8'hDA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       sel_n,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       rdy_pull_low
);

  localparam int COL_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int ROW_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic             s_cmd, s_addr, s_sel_n, s_rd_n, wr_rise, rd_fall;
  logic [7:0]       s_dq;
  mode_e            mode;
  logic             busy, col_load, id_load;
  logic [COL_W-1:0] col_start;
  logic [ROW_W-1:0] row_sel;

  nand_strobe_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_latch  (cmd_latch),
    .addr_latch (addr_latch),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .sel_n      (sel_n),
    .dq_in      (dq_in),
    .s_cmd      (s_cmd),
    .s_addr     (s_addr),
    .s_sel_n    (s_sel_n),
    .s_rd_n     (s_rd_n),
    .s_dq       (s_dq),
    .wr_rise    (wr_rise),
    .rd_fall    (rd_fall)
  );

  nand_cmd_fsm #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rise   (wr_rise),
    .s_cmd     (s_cmd),
    .s_addr    (s_addr),
    .s_sel_n   (s_sel_n),
    .s_dq      (s_dq),
    .mode      (mode),
    .busy      (busy),
    .col_load  (col_load),
    .id_load   (id_load),
    .col_start (col_start),
    .row_sel   (row_sel)
  );

  nand_data_port #(
    .COL_W       (COL_W),
    .ROW_W       (ROW_W),
    .MAKER_CODE  (MAKER_CODE),
    .DEVICE_CODE (DEVICE_CODE)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fall   (rd_fall),
    .s_rd_n    (s_rd_n),
    .s_sel_n   (s_sel_n),
    .mode      (mode),
    .col_load  (col_load),
    .id_load   (id_load),
    .col_start (col_start),
    .row_sel   (row_sel),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  assign rdy_pull_low = busy;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rdy_pull_low && !dq_oe)); // R1

endmodule

// File: tb/tb_nand_responder.sv
module tb_nand_responder;

  localparam int CLK_PERIOD = 10;
  localparam int PAGES      = 4;
  localparam int PB         = 16;
  localparam int BUSY       = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_latch = 1'b0, addr_latch = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, sel_n = 1'b0;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out;
  logic       dq_oe, rdy;

  int checks = 0, errors = 0;
  int run = 0, last_run = 0;
  bit may_busy = 1'b0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_responder #(.PAGES(PAGES), .PAGE_BYTES(PB), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
    .wr_n(wr_n), .rd_n(rd_n), .sel_n(sel_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdy_pull_low(rdy)
  );

  function automatic logic [7:0] page_val(int row, int col);
    return 8'((8'h17 + (row % PAGES) * 29 + (col % PB) * 7) % 256);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference monitor, every clock: busy only where the model allows it, run length tracked
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdy && !may_busy) begin
        errors++;
        $display("FAIL R7 actual=1 expected=0 (busy not expected)");
      end
      if (rdy) run++;
      else begin
        if (run != 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic wr(bit is_cmd, logic [7:0] b);
    @(negedge clk);
    cmd_latch = is_cmd; addr_latch = !is_cmd; dq_in = b; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cmd_latch = 1'b0; addr_latch = 1'b0;
  endtask

  task automatic rd(string req, bit drive);
    logic [7:0] e;
    @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(req, dq_oe, drive);
    if (drive) begin
      e = expq.pop_front();
      check(req, dq_out, e);
    end
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", dq_oe, 0);
  endtask

  task automatic page_cmd(logic [7:0] a0, logic [7:0] a1, logic [7:0] a2,
                          logic [7:0] a3, logic [7:0] a4);
    wr(1, 8'h00);
    wr(0, a0); wr(0, a1); wr(0, a2); wr(0, a3); wr(0, a4);
    may_busy = 1'b1;
    wr(1, 8'h30);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && rdy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    may_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rdy, 0);
    check("R1", dq_oe, 0);
    rd("R1", 0);

    // identification query
    wr(1, 8'h90); wr(0, 8'h00);
    expq.push_back(8'hEC); expq.push_back(8'hDA); expq.push_back(8'h00);
    rd("R2", 1); rd("R2", 1); rd("R2", 1);

    // page read row 2 column 3
    page_cmd(8'h03, 8'h00, 8'h02, 8'h00, 8'h00);
    wait_ready();
    check("R4", last_run, BUSY);
    for (int c = 3; c < 8; c++) expq.push_back(page_val(2, c));
    for (int k = 0; k < 5; k++) rd("R3", 1);

    // wrap, discarded column high byte, row 1
    page_cmd(8'h0E, 8'h05, 8'h01, 8'h00, 8'h00);
    wait_ready();
    for (int c = 14; c < 18; c++) expq.push_back(page_val(1, c));
    for (int k = 0; k < 4; k++) rd("R5", 1);

    // deselected read strobe ignored, column not advanced
    sel_n = 1'b1;
    rd("R6", 0);
    sel_n = 1'b0;
    expq.push_back(page_val(1, 2));
    rd("R6", 1);

    // row high bits ignored: row 6 maps to row 2
    page_cmd(8'h00, 8'h00, 8'h06, 8'h07, 8'h00);
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    sel_n = 1'b0;
    wait_ready();
    check("R6", last_run, BUSY);
    expq.push_back(page_val(2, 0)); expq.push_back(page_val(2, 1));
    rd("R5", 1); rd("R5", 1);

    // confirm without full address
    wr(1, 8'h00); wr(0, 8'h01); wr(0, 8'h02);
    wr(1, 8'h30);
    repeat (4) @(negedge clk);
    check("R7", rdy, 0);
    rd("R7", 0);

    // writes and reads during busy are ignored
    page_cmd(8'h05, 8'h00, 8'h03, 8'h00, 8'h00);
    wr(1, 8'h90); wr(0, 8'h00);
    rd("R8", 0);
    wait_ready();
    check("R8", last_run, BUSY);
    expq.push_back(page_val(3, 5));
    rd("R8", 1);

    // reset during busy
    page_cmd(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    wr(1, 8'hFF);
    check("R9", rdy, 0);
    may_busy = 1'b0;
    rd("R9", 0);

    // strobes while deselected do not start an identification query
    sel_n = 1'b1;
    wr(1, 8'h90); wr(0, 8'h00);
    sel_n = 1'b0;
    rd("R6", 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule